// File: doc/BRIEF.md
# SDRAM Command Legality Checker

This block watches the control pins of a four-bank double-data-rate SDRAM bus and turns the pin levels on every clock edge into a command. It keeps a record of which banks are open and how many cycles have passed since each relevant event. Any command that targets a bank in the wrong state, or that arrives before a required minimum delay has passed, is flagged. The error flag carries a reason code. A memory controller under test, or a bus model in a larger simulation, connects to the pins in parallel and reads the flag and the per-bank state.

All minimum delays are parameters counted in clock cycles, and so is the burst length. A command that is flagged is treated as if the memory never accepted it, so it changes no bank state and restarts no timer. The next legal command is then judged against the state the bus really has. Auto-precharge is modelled as an internal close of the bank, and the checker works out the cycle in which that close happens.

Top module: `sdram_cmd_checker`

## Requirements
- R1: The pins (cs_n, ras_n, cas_n, we_n) decode as follows: L,L,H,H activate (code 2); L,H,L,H read (3); L,H,L,L write (4); L,L,H,L precharge (5); L,L,L,H refresh (6); L,L,L,L mode set (7); L,H,H,L burst stop (8); L,H,H,H no-op (1). cs_n high gives deselect (0). With cs_n low and cke low, the command is reported as no-op (1), is not checked and does nothing.
- R2: The decoded command, the error flag and the reason code appear on the outputs in the cycle after the edge that sampled the pins. The reason codes are 0 for none, 1 for a wrong bank state and 2 for a timing violation. A state error takes priority over a timing error. The flag is high exactly when the code is non-zero. A rejected command changes no bank state and restarts no timer.
- R3: A read or write to a closed bank is a state error, and so is an activate to a bank that is already open.
- R4: A read or write that comes fewer than T_RCD cycles after the activate of its bank is a timing error.
- R5: An activate is a timing error if it comes fewer than T_RRD cycles after the last accepted activate to any bank, or fewer than T_RP cycles after its bank was closed.
- R6: A precharge with a10 low closes the bank given by ba. With a10 high it closes every bank and ba is ignored. A precharge to an idle bank is legal and changes nothing. A precharge that closes a bank with a write less than BL/2+T_WR cycles earlier is a timing error.
- R7: A read or write with a10 high requests auto-precharge, and bank_ap_o shows the request is pending. The bank closes in the first cycle in which at least T_RAS cycles have passed since its activate and at least BL/2 cycles (read) or BL/2+T_WR cycles (write) have passed since the command. For T_RP, that cycle counts as the precharge. While the request is pending, a read, write or precharge to that bank is a state error.
- R8: A refresh or mode set while any bank is open is a state error. A refresh is a timing error if any bank was closed fewer than T_RP cycles earlier. A refresh or an activate fewer than T_RFC cycles after an accepted refresh is a timing error.
- R9: Any command other than deselect or no-op that comes fewer than T_MRD cycles after an accepted mode set is a timing error.
- R10: A burst stop in the BL/2 cycles that follow an accepted write is a state error. At any other time it is legal.
- R11: During and after a synchronous reset, all banks are closed, no request is pending, the command output is 0 and there is no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank address |
| a10 | input | 1 | Address bit 10 (all-bank / auto-precharge) |
| cmd_o | output | 4 | Decoded command code |
| err_o | output | 1 | Violation flag for the command sampled on the previous edge |
| err_code_o | output | 2 | Reason code: 0 none, 1 state, 2 timing |
| bank_open_o | output | NBANK | One bit per bank, high while the bank is open |
| bank_ap_o | output | NBANK | One bit per bank, high while auto-precharge is pending |

## Verification
A directed sequence first walks each rule at its boundary. It places a command one cycle inside a minimum delay and then exactly on it, which shows whether every comparison is off by one. Mixed patterns follow: commands to a closed bank under a pending mode-set gap show the state-over-timing priority. Single-bank and all-bank precharges, including one to an idle bank, show the bank mask at work. A read with auto-precharge shows the internal close and that it starts the row-precharge wait. A long pseudo-random stream of pin levels, with clock-enable sometimes low, is then checked against a behavioural model on every clock. That stream reaches interactions between rules that the directed part does not.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_WR    = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_REF   = 4'd6,
    CMD_MRS   = 4'd7,
    CMD_BST   = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_STATE  = 2'd1,
    ERR_TIMING = 2'd2
  } err_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_chk_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  // R1: pin levels to command code; clock enable low masks the command
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else if (!cke) begin
      cmd = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int CW     = 5,
  parameter int T_RAS  = 6,
  parameter int RD_GAP = 2,
  parameter int WR_GAP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_i,
  input  logic          close_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          ap_req_i,
  output logic          open_o,
  output logic          ap_o,
  output logic [CW-1:0] since_act_o,
  output logic [CW-1:0] since_pre_o,
  output logic [CW-1:0] since_wr_o
);
  localparam logic [CW-1:0] CMAX   = '1;
  localparam logic [CW-1:0] ONE    = CW'(1);
  localparam logic [CW-1:0] RAS_C  = CW'(T_RAS);
  localparam logic [CW-1:0] RDG_C  = CW'(RD_GAP);
  localparam logic [CW-1:0] WRG_C  = CW'(WR_GAP);

  logic [CW-1:0] since_rw;
  logic          ap_is_wr;
  logic          ap_fire;

  // R7: internal close once both the row-active minimum and burst/recovery are met
  assign ap_fire = ap_o && (since_act_o >= RAS_C) &&
                   (since_rw >= (ap_is_wr ? WRG_C : RDG_C));

  always_ff @(posedge clk) begin
    if (rst) begin
      open_o      <= 1'b0;
      ap_o        <= 1'b0;
      ap_is_wr    <= 1'b0;
      since_act_o <= CMAX;
      since_pre_o <= CMAX;
      since_wr_o  <= CMAX;
      since_rw    <= CMAX;
    end else begin
      since_act_o <= (since_act_o == CMAX) ? CMAX : since_act_o + ONE;
      since_pre_o <= (since_pre_o == CMAX) ? CMAX : since_pre_o + ONE;
      since_wr_o  <= (since_wr_o  == CMAX) ? CMAX : since_wr_o  + ONE;
      since_rw    <= (since_rw    == CMAX) ? CMAX : since_rw    + ONE;
      if (act_i) begin
        open_o      <= 1'b1;
        since_act_o <= ONE;
      end
      if (close_i || ap_fire) begin
        open_o      <= 1'b0;
        ap_o        <= 1'b0;
        since_pre_o <= ONE;
      end
      if (rd_i || wr_i) begin
        since_rw <= ONE;
        ap_o     <= ap_req_i;
        ap_is_wr <= wr_i;
      end
      if (wr_i) since_wr_o <= ONE;
    end
  end
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = $clog2(NBANK),
  parameter int BL     = 4,
  parameter int T_RCD  = 3,
  parameter int T_RRD  = 2,
  parameter int T_RP   = 3,
  parameter int T_WR   = 2,
  parameter int T_RAS  = 6,
  parameter int T_RFC  = 10,
  parameter int T_MRD  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic              a10,
  output logic [3:0]        cmd_o,
  output logic              err_o,
  output logic [1:0]        err_code_o,
  output logic [NBANK-1:0]  bank_open_o,
  output logic [NBANK-1:0]  bank_ap_o
);
  localparam int BURST_CLK = BL / 2;
  localparam int WR_GAP    = BURST_CLK + T_WR;
  localparam int CW = $clog2(T_RCD + T_RRD + T_RP + T_WR + T_RAS + T_RFC + T_MRD + BURST_CLK + 2);
  localparam int BW = $clog2(BURST_CLK + 1);
  localparam logic [CW-1:0] CMAX  = '1;
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] RCD_C = CW'(T_RCD);
  localparam logic [CW-1:0] RRD_C = CW'(T_RRD);
  localparam logic [CW-1:0] RP_C  = CW'(T_RP);
  localparam logic [CW-1:0] WRG_C = CW'(WR_GAP);
  localparam logic [CW-1:0] RFC_C = CW'(T_RFC);
  localparam logic [CW-1:0] MRD_C = CW'(T_MRD);
  localparam logic [BW-1:0] BST_C = BW'(BURST_CLK);

  cmd_e              cmd_w;
  logic [NBANK-1:0]  open_v, ap_v, mask;
  logic [NBANK-1:0]  do_act, do_close, do_rd, do_wr;
  logic [CW-1:0]     s_act [NBANK];
  logic [CW-1:0]     s_pre [NBANK];
  logic [CW-1:0]     s_wr  [NBANK];
  logic [CW-1:0]     g_act, g_ref, g_mrs;
  logic [BW-1:0]     wr_left;
  logic              st_err, tm_err, real_cmd, legal, pre_recent, wr_recov;

  sdram_cmd_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd_w)
  );

  always_comb begin
    mask       = a10 ? '1 : (NBANK'(1) << ba);
    pre_recent = 1'b0;
    wr_recov   = 1'b0;
    for (int i = 0; i < NBANK; i++) begin
      if (s_pre[i] < RP_C) pre_recent = 1'b1;
      if (mask[i] && open_v[i] && (s_wr[i] < WRG_C)) wr_recov = 1'b1;
    end
    st_err = 1'b0;
    tm_err = 1'b0;
    case (cmd_w)
      CMD_ACT: begin
        st_err = open_v[ba];
        tm_err = (s_pre[ba] < RP_C) || (g_act < RRD_C) || (g_ref < RFC_C);
      end
      CMD_RD, CMD_WR: begin
        st_err = !open_v[ba] || ap_v[ba];
        tm_err = s_act[ba] < RCD_C;
      end
      CMD_PRE: begin
        st_err = |(mask & ap_v);
        tm_err = wr_recov;
      end
      CMD_REF: begin
        st_err = |open_v;
        tm_err = (g_ref < RFC_C) || pre_recent;
      end
      CMD_MRS: st_err = |open_v;
      CMD_BST: st_err = (wr_left != '0);
      default: ;
    endcase
    real_cmd = (cmd_w != CMD_DESEL) && (cmd_w != CMD_NOP);
    if (real_cmd && (g_mrs < MRD_C)) tm_err = 1'b1;
    legal = real_cmd && !st_err && !tm_err;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit;
    assign hit         = (ba == BANK_W'(g));
    assign do_act[g]   = legal && (cmd_w == CMD_ACT) && hit;
    assign do_rd[g]    = legal && (cmd_w == CMD_RD) && hit;
    assign do_wr[g]    = legal && (cmd_w == CMD_WR) && hit;
    assign do_close[g] = legal && (cmd_w == CMD_PRE) && mask[g] && open_v[g];

    sdram_bank_track #(
      .CW(CW), .T_RAS(T_RAS), .RD_GAP(BURST_CLK), .WR_GAP(WR_GAP)
    ) u_trk (
      .clk(clk), .rst(rst),
      .act_i(do_act[g]), .close_i(do_close[g]), .rd_i(do_rd[g]), .wr_i(do_wr[g]),
      .ap_req_i(a10),
      .open_o(open_v[g]), .ap_o(ap_v[g]),
      .since_act_o(s_act[g]), .since_pre_o(s_pre[g]), .since_wr_o(s_wr[g])
    );
  end

  assign bank_open_o = open_v;
  assign bank_ap_o   = ap_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o      <= 4'd0;
      err_o      <= 1'b0;
      err_code_o <= ERR_NONE;
      g_act      <= CMAX;
      g_ref      <= CMAX;
      g_mrs      <= CMAX;
      wr_left    <= '0;
    end else begin
      cmd_o      <= cmd_w;
      err_o      <= st_err || tm_err;
      err_code_o <= st_err ? ERR_STATE : (tm_err ? ERR_TIMING : ERR_NONE);
      g_act <= (g_act == CMAX) ? CMAX : g_act + ONE;
      g_ref <= (g_ref == CMAX) ? CMAX : g_ref + ONE;
      g_mrs <= (g_mrs == CMAX) ? CMAX : g_mrs + ONE;
      if (legal && cmd_w == CMD_ACT) g_act <= ONE;
      if (legal && cmd_w == CMD_REF) g_ref <= ONE;
      if (legal && cmd_w == CMD_MRS) g_mrs <= ONE;
      if (legal && cmd_w == CMD_WR) wr_left <= BST_C;
      else if (wr_left != '0)       wr_left <= wr_left - BW'(1);
    end
  end
endmodule

// File: rtl/sdram_cmd_checker_sva.sv
module sdram_cmd_checker_sva #(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] ba,
  input logic [3:0]        cmd_o,
  input logic              err_o,
  input logic [1:0]        err_code_o,
  input logic [NBANK-1:0]  bank_open_o,
  input logic [NBANK-1:0]  bank_ap_o
);
  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (cmd_o == 4'd0 && !err_o));

  a_r2_flag_matches_code: assert property (@(posedge clk) disable iff (rst)
    err_o == (err_code_o != 2'd0));

  a_r3_act_open_bank: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cke && !ras_n && cas_n && we_n && bank_open_o[ba]) |=> (err_code_o == 2'd1));

  a_r3_read_closed_bank: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cke && ras_n && !cas_n && we_n && !bank_open_o[ba]) |=> (err_code_o == 2'd1));

  a_r8_refresh_busy: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cke && !ras_n && !cas_n && we_n && (|bank_open_o)) |=> (err_code_o == 2'd1));

  for (genvar g = 0; g < NBANK; g++) begin : g_chk
    a_r2_open_needs_act: assert property (@(posedge clk) disable iff (rst)
      $rose(bank_open_o[g]) |-> (cmd_o == 4'd2 && !err_o));
    a_r7_pending_only_open: assert property (@(posedge clk) disable iff (rst)
      bank_ap_o[g] |-> bank_open_o[g]);
  end
endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva #(.NBANK(NBANK), .BANK_W(BANK_W)) u_sva (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ba(ba), .cmd_o(cmd_o), .err_o(err_o), .err_code_o(err_code_o),
  .bank_open_o(bank_open_o), .bank_ap_o(bank_ap_o)
);

// File: tb/test_sdram_cmd_checker.sv
`timescale 1ns/1ps
module test_sdram_cmd_checker;
  localparam int NB = 4, BL = 4, T_RCD = 3, T_RRD = 2, T_RP = 3, T_WR = 2;
  localparam int T_RAS = 6, T_RFC = 10, T_MRD = 2;
  localparam int FAR = -1000;

  logic clk = 1'b0, rst = 1'b1, cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1;
  logic we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [3:0] cmd_o;
  logic err_o;
  logic [1:0] err_code_o;
  logic [3:0] bank_open_o, bank_ap_o;

  always #2 clk = ~clk;

  sdram_cmd_checker #(.NBANK(NB), .BL(BL), .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RP(T_RP),
    .T_WR(T_WR), .T_RAS(T_RAS), .T_RFC(T_RFC), .T_MRD(T_MRD)) i_sdram_cmd_checker (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10), .cmd_o(cmd_o), .err_o(err_o), .err_code_o(err_code_o),
    .bank_open_o(bank_open_o), .bank_ap_o(bank_ap_o));

  int checks = 0, fails = 0;
  string cur_req = "R11";
  bit done = 0;

  // behavioural model: event times in absolute cycles
  int n;
  int m_open[NB], m_ap[NB], m_apwr[NB], e_act[NB], e_pre[NB], e_rw[NB], e_wr[NB];
  int e_gact, e_gref, e_gmrs, e_wrcmd;
  int x_cmd, x_err, x_code;
  logic [3:0] x_open, x_ap;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    n = 0;
    for (int i = 0; i < NB; i++) begin
      m_open[i] = 0; m_ap[i] = 0; m_apwr[i] = 0;
      e_act[i] = FAR; e_pre[i] = FAR; e_rw[i] = FAR; e_wr[i] = FAR;
    end
    e_gact = FAR; e_gref = FAR; e_gmrs = FAR; e_wrcmd = FAR;
  endfunction

  function automatic void model_step();
    int c, b, gap;
    bit st, tm;
    bit [3:0] msk;
    b = int'(ba);
    if (cs_n) c = 0;
    else if (!cke) c = 1;
    else case ({ras_n, cas_n, we_n})
      3'b011: c = 2; 3'b101: c = 3; 3'b100: c = 4; 3'b010: c = 5;
      3'b001: c = 6; 3'b000: c = 7; 3'b110: c = 8; default: c = 1;
    endcase
    msk = a10 ? 4'hF : (4'h1 << b);
    st = 0; tm = 0;
    case (c)
      2: begin
        st = m_open[b] != 0;
        tm = (n - e_pre[b] < T_RP) || (n - e_gact < T_RRD) || (n - e_gref < T_RFC);
      end
      3, 4: begin
        st = (m_open[b] == 0) || (m_ap[b] != 0);
        tm = n - e_act[b] < T_RCD;
      end
      5: for (int i = 0; i < NB; i++) if (msk[i]) begin
        if (m_ap[i] != 0) st = 1;
        if (m_open[i] != 0 && n - e_wr[i] < BL/2 + T_WR) tm = 1;
      end
      6: for (int i = 0; i < NB; i++) begin
        if (m_open[i] != 0) st = 1;
        if (n - e_pre[i] < T_RP) tm = 1;
        if (n - e_gref < T_RFC) tm = 1;
      end
      7: for (int i = 0; i < NB; i++) if (m_open[i] != 0) st = 1;
      8: st = (n - e_wrcmd >= 1) && (n - e_wrcmd <= BL/2);
      default: ;
    endcase
    if (c >= 2 && n - e_gmrs < T_MRD) tm = 1;
    x_cmd = c; x_err = (st || tm) ? 1 : 0; x_code = st ? 1 : (tm ? 2 : 0);
    for (int i = 0; i < NB; i++) begin
      gap = m_apwr[i] != 0 ? BL/2 + T_WR : BL/2;
      if (m_ap[i] != 0 && n - e_act[i] >= T_RAS && n - e_rw[i] >= gap) begin
        m_open[i] = 0; m_ap[i] = 0; e_pre[i] = n;
      end
    end
    if (c >= 2 && x_err == 0) begin
      case (c)
        2: begin m_open[b] = 1; e_act[b] = n; e_gact = n; end
        3, 4: begin
          e_rw[b] = n; m_ap[b] = a10 ? 1 : 0; m_apwr[b] = (c == 4) ? 1 : 0;
          if (c == 4) begin e_wr[b] = n; e_wrcmd = n; end
        end
        5: for (int i = 0; i < NB; i++)
             if (msk[i] && m_open[i] != 0) begin m_open[i] = 0; e_pre[i] = n; end
        6: e_gref = n;
        7: e_gmrs = n;
        default: ;
      endcase
    end
    for (int i = 0; i < NB; i++) begin
      x_open[i] = m_open[i] != 0;
      x_ap[i]   = m_ap[i] != 0;
    end
    n++;
  endfunction

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    checks++;
    if ({cmd_o, err_o, err_code_o, bank_open_o, bank_ap_o} !==
        {x_cmd[3:0], x_err[0], x_code[1:0], x_open, x_ap}) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%h/%b/%0d/%b/%b expected=%h/%b/%0d/%b/%b", cur_req, n,
        cmd_o, err_o, err_code_o, bank_open_o, bank_ap_o,
        x_cmd[3:0], x_err[0], x_code, x_open, x_ap);
    end
  endtask

  task automatic pins(bit k, bit c, bit r, bit ca, bit w, int b, bit a);
    @(negedge clk);
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b[1:0]; a10 = a;
    tick();
  endtask

  // codes per R1
  task automatic op(int code, int b = 0, bit a = 0);
    case (code)
      0: pins(1, 1, 1, 1, 1, b, a);
      2: pins(1, 0, 0, 1, 1, b, a);
      3: pins(1, 0, 1, 0, 1, b, a);
      4: pins(1, 0, 1, 0, 0, b, a);
      5: pins(1, 0, 0, 1, 0, b, a);
      6: pins(1, 0, 0, 0, 1, b, a);
      7: pins(1, 0, 0, 0, 0, b, a);
      8: pins(1, 0, 1, 1, 0, b, a);
      default: pins(1, 0, 1, 1, 1, b, a);
    endcase
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) op(1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    int c;
    // R11 reset state
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R11 open during reset", int'(bank_open_o), 0);
      chk("R11 err during reset", int'(err_o), 0);
      chk("R11 cmd during reset", int'(cmd_o), 0);
    end
    @(negedge clk); rst = 1'b0;
    model_reset();

    cur_req = "R1";
    pins(0, 0, 0, 1, 1, 0, 0);
    chk("R1 cke low gives no-op", int'(cmd_o), 1);
    chk("R1 cke low opens nothing", int'(bank_open_o), 0);
    op(0);
    chk("R1 deselect", int'(cmd_o), 0);

    cur_req = "R3";
    op(3, 0);
    chk("R3 read closed bank", int'(err_code_o), 1);

    cur_req = "R5";
    op(2, 0);
    chk("R1 activate code", int'(cmd_o), 2);
    op(2, 1);
    chk("R5 tRRD short", int'(err_code_o), 2);
    op(2, 1);
    chk("R5 tRRD met", int'(err_code_o), 0);
    cur_req = "R4";
    op(3, 1);
    chk("R4 tRCD short", int'(err_code_o), 2);
    op(3, 0);
    chk("R4 tRCD met", int'(err_code_o), 0);
    cur_req = "R3";
    op(2, 0);
    chk("R3 activate open bank", int'(err_code_o), 1);

    cur_req = "R10";
    op(4, 0);
    op(8);
    chk("R10 burst stop in write", int'(err_code_o), 1);
    cur_req = "R6";
    op(5, 0);
    chk("R6 write recovery short", int'(err_code_o), 2);
    op(1);
    op(5, 0);
    chk("R6 write recovery met", int'(err_code_o), 0);
    chk("R6 bank0 closed", int'(bank_open_o), 2);
    cur_req = "R5";
    op(2, 0);
    chk("R5 tRP short", int'(err_code_o), 2);
    op(1);
    op(2, 0);
    chk("R5 tRP met", int'(err_code_o), 0);
    cur_req = "R6";
    op(5, 2);
    chk("R6 idle precharge legal", int'(err_code_o), 0);
    chk("R6 idle precharge no effect", int'(bank_open_o), 3);
    cur_req = "R10";
    op(8);
    chk("R10 burst stop idle legal", int'(err_code_o), 0);
    cur_req = "R6";
    op(5, 3, 1);
    chk("R6 precharge all", int'(bank_open_o), 0);

    cur_req = "R8";
    op(6);
    chk("R8 refresh inside tRP", int'(err_code_o), 2);
    op(1);
    op(6);
    chk("R8 refresh legal", int'(err_code_o), 0);
    op(2, 3);
    chk("R8 activate inside tRFC", int'(err_code_o), 2);
    op(6);
    chk("R8 refresh inside tRFC", int'(err_code_o), 2);
    idle(10);

    cur_req = "R2";
    op(7);
    chk("R9 mode set legal", int'(err_code_o), 0);
    op(3, 2);
    chk("R2 state beats timing", int'(err_code_o), 1);
    op(2, 2);
    chk("R9 gap met", int'(err_code_o), 0);
    cur_req = "R8";
    op(7);
    chk("R8 mode set with open bank", int'(err_code_o), 1);
    op(6);
    chk("R8 refresh with open bank", int'(err_code_o), 1);
    op(5, 0, 1);
    idle(3);
    cur_req = "R9";
    op(7);
    op(2, 0);
    chk("R9 activate inside gap", int'(err_code_o), 2);
    idle(2);

    cur_req = "R7";
    op(2, 1);
    idle(2);
    op(3, 1, 1);
    chk("R7 read with auto-precharge", int'(err_code_o), 0);
    op(3, 1);
    chk("R7 read while pending", int'(err_code_o), 1);
    op(5, 1);
    chk("R7 precharge while pending", int'(err_code_o), 1);
    chk("R7 pending flag", int'(bank_ap_o[1]), 1);
    op(1);
    chk("R7 bank closed by auto-precharge", int'(bank_open_o[1]), 0);
    op(2, 1);
    chk("R7 close starts tRP", int'(err_code_o), 2);
    idle(3);
    op(2, 3);
    idle(2);
    op(4, 3, 1);
    idle(6);
    chk("R7 write auto-precharge closed", int'(bank_open_o[3]), 0);

    cur_req = "R2";
    lfsr = 16'hACE1;
    for (int k = 0; k < 1500; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      c = (lfsr[3:0] < 4'd9) ? int'(lfsr[3:0]) : (int'(lfsr[3:0]) - 9) % 4 + 2;
      if (lfsr[15:12] == 4'd0)
        pins(0, lfsr[8], lfsr[9], lfsr[10], lfsr[11], int'(lfsr[5:4]), lfsr[6]);
      else
        op(c, int'(lfsr[5:4]), lfsr[7:6] == 2'd0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule